// File: doc/BRIEF.md
# Indirect Guest-Bus Access Bridge

This bridge lets a host reach two slow 8-bit guest peripherals through a single 32-bit command/status register. The register sits in a small host register window. To use it, the host writes one command word to that register. The word carries:

- a byte value,
- a guest select,
- a phase select, which chooses between the guest's address latch and its data port,
- a direction bit.

The bridge then runs one timed cycle on the guest bus. While the cycle runs, a pending flag in the same register stays set.

A complete guest register access takes two commands. The first is an address-phase write, which loads the bridge's own address latch for that guest. The second is a data-phase read or write. For a data-phase cycle, the bridge presents the latched address together with a chip select and a read or write strobe.

Every cycle has the same shape: one setup clock, a strobe of programmable width, and one hold clock. While the flag is set, new commands are dropped, so the host must poll the flag before issuing the next command. After a read, the fetched byte stays in the low byte of the register until the next read completes.

Top module: `guest_bus_bridge`

## Requirements
- R1: After synchronous active-low reset, the following all hold: the pending flag (bit 25) reads 0; both chip selects, `gb_rd_n` and `gb_wr_n` are high; `gb_ale` is low; the read-data byte is 0; both guest address latches read back as 0.
- R2: A host write is a command only when `host_addr` equals `CMD_OFF` (default 0x200). A write at any other offset starts no cycle.
- R3: The pending flag (bit 25) reads 1 from the clock after an accepted command for exactly STRB_CLKS+2 clocks, then reads 0. A chip select is low exactly while pending is set.
- R4: Bit 20 of the command selects the guest (0 or 1). Only that guest's active-low chip select `gb_cs_n[guest]` goes low during the cycle.
- R5: Every cycle has one setup clock with no strobe active, then the strobe active for STRB_CLKS clocks, then one hold clock with no strobe active. At most one strobe is ever active.
- R6: A command with bit 23 = 1 (write) and bit 16 = 0 (address phase) loads bits 7:0 into that guest's address latch when accepted. The strobe for this cycle is `gb_ale` (active high), and `gb_addr` and `gb_dout` carry the byte.
- R7: A command with bit 23 = 1 and bit 16 = 1 (data write) pulses `gb_wr_n` low, with `gb_dout` = bits 7:0 and `gb_addr` = the selected guest's latch.
- R8: A command with bit 23 = 0 and bit 16 = 1 (data read) pulses `gb_rd_n` low and presents the guest's latch on `gb_addr`. `gb_din` is sampled on the last clock of the strobe, and the sampled value appears in bits 7:0 once pending clears.
- R9: A command with bit 23 = 0 and bit 16 = 0 (address read) activates no strobe. When it completes, bits 7:0 return the selected guest's address latch.
- R10: The two guests' address latches are independent. An address write to one guest never changes the other guest's latch.
- R11: A command written while pending is set is ignored. The running cycle's select, address, data and strobes are unchanged, and no latch changes.
- R12: When `host_addr` = `CMD_OFF`, every bit other than 25 and 7:0 reads 0. Bits 7:0 hold the last read result until the next read completes, including across write commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 12 | Host register byte offset |
| host_we | input | 1 | Host write enable, one clock per write |
| host_wdata | input | 32 | Host write data (command word) |
| host_rdata | output | 32 | Status/read data for the addressed offset |
| gb_cs_n | output | 2 | Active-low chip select, one per guest |
| gb_ale | output | 1 | Address latch strobe, active high |
| gb_rd_n | output | 1 | Read strobe, active low |
| gb_wr_n | output | 1 | Write strobe, active low |
| gb_addr | output | 8 | Guest register address |
| gb_dout | output | 8 | Byte driven to the guest |
| gb_din | input | 8 | Byte returned by the guest |

## Verification
Two things can fall in the same clock: a host command write and a guest cycle that is still running, including its final hold clock. The bench provokes this by injecting a conflicting address-write to the other guest at a random clock inside the cycle. It then judges the result in two ways. First, every clock of the running cycle must keep its original select, address, data and strobe. Second, later address reads must show that neither latch moved.

A second overlap concerns the read sample itself. The bench changes `gb_din` exactly at the last strobe clock and again right after it, so only a sample taken on that clock returns the expected byte.

// File: rtl/gbb_pkg.sv
package gbb_pkg;

    localparam int POS_PEND  = 25;
    localparam int POS_DIR   = 23;
    localparam int POS_GSEL  = 20;
    localparam int POS_RSEL  = 16;
    localparam int BYTE_W    = 8;
    localparam int NUM_GUEST = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_STRB  = 2'd2,
        ST_HOLD  = 2'd3
    } gbb_state_e;

    typedef struct packed {
        logic              guest;
        logic              wr;
        logic              dphase;
        logic [BYTE_W-1:0] val;
    } gbb_cmd_t;

endpackage

// File: rtl/gbb_decode.sv
module gbb_decode
    import gbb_pkg::*;
#(
    parameter int              HADDR_W = 12,
    parameter logic [HADDR_W-1:0] CMD_OFF = 12'h200
) (
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_we,
    input  logic [31:0]        host_wdata,
    input  logic               busy,
    output logic               launch,
    output gbb_cmd_t           cmd
);
    logic hit;

    always_comb begin
        hit        = (host_addr == CMD_OFF);
        launch     = hit && host_we && !busy;
        cmd.guest  = host_wdata[POS_GSEL];
        cmd.wr     = host_wdata[POS_DIR];
        cmd.dphase = host_wdata[POS_RSEL];
        cmd.val    = host_wdata[BYTE_W-1:0];
    end
endmodule

// File: rtl/gbb_seq.sv
module gbb_seq
    import gbb_pkg::*;
#(
    parameter int STRB_CLKS = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     launch,
    input  gbb_cmd_t cmd_in,
    output logic     busy,
    output logic     cs_act,
    output logic     strb_act,
    output logic     strb_last,
    output gbb_cmd_t cmd_cur
);
    localparam int CW = (STRB_CLKS > 1) ? $clog2(STRB_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STRB_CLKS - 1);

    typedef struct packed {
        gbb_state_e    st;
        logic [CW-1:0] cnt;
        gbb_cmd_t      cmd;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (launch) begin
                    s_d.st  = ST_SETUP;
                    s_d.cmd = cmd_in;
                    s_d.cnt = '0;
                end
            end
            ST_SETUP: begin
                s_d.st  = ST_STRB;
                s_d.cnt = '0;
            end
            ST_STRB: begin
                if (s_q.cnt == CNT_LAST) begin
                    s_d.st = ST_HOLD;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, cmd: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy      = (s_q.st != ST_IDLE);
        cs_act    = busy;
        strb_act  = (s_q.st == ST_STRB);
        strb_last = strb_act && (s_q.cnt == CNT_LAST);
        cmd_cur   = s_q.cmd;
    end
endmodule

// File: rtl/gbb_latch.sv
module gbb_latch
    import gbb_pkg::*;
#(
    parameter int NUM = NUM_GUEST,
    parameter int W   = BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [$clog2(NUM)-1:0] wsel,
    input  logic [W-1:0]           wval,
    input  logic [$clog2(NUM)-1:0] rsel,
    output logic [W-1:0]           rval
);
    logic [W-1:0] lat_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_lat
        logic [W-1:0] lat_d;
        always_comb begin
            lat_d = lat_q[g];
            if (we && (wsel == g)) lat_d = wval;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) lat_q[g] <= '0;
            else        lat_q[g] <= lat_d;
        end
    end

    assign rval = lat_q[rsel];
endmodule

// File: rtl/guest_bus_bridge.sv
module guest_bus_bridge
    import gbb_pkg::*;
#(
    parameter int                 HADDR_W   = 12,
    parameter logic [HADDR_W-1:0] CMD_OFF   = 12'h200,
    parameter int                 STRB_CLKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_we,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic [1:0]         gb_cs_n,
    output logic               gb_ale,
    output logic               gb_rd_n,
    output logic               gb_wr_n,
    output logic [7:0]         gb_addr,
    output logic [7:0]         gb_dout,
    input  logic [7:0]         gb_din
);
    logic     launch, busy, cs_act, strb_act, strb_last;
    gbb_cmd_t cmd_new, cmd_cur;
    logic [BYTE_W-1:0] lat_val;

    gbb_decode #(.HADDR_W(HADDR_W), .CMD_OFF(CMD_OFF)) u_dec (
        .host_addr (host_addr),
        .host_we   (host_we),
        .host_wdata(host_wdata),
        .busy      (busy),
        .launch    (launch),
        .cmd       (cmd_new)
    );

    gbb_seq #(.STRB_CLKS(STRB_CLKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .cmd_in   (cmd_new),
        .busy     (busy),
        .cs_act   (cs_act),
        .strb_act (strb_act),
        .strb_last(strb_last),
        .cmd_cur  (cmd_cur)
    );

    gbb_latch #(.NUM(NUM_GUEST), .W(BYTE_W)) u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (launch && cmd_new.wr && !cmd_new.dphase),
        .wsel (cmd_new.guest),
        .wval (cmd_new.val),
        .rsel (cmd_cur.guest),
        .rval (lat_val)
    );

    // read-data holding register, two-process
    typedef struct packed {
        logic [BYTE_W-1:0] rd;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (strb_last && !cmd_cur.wr) begin
            h_d.rd = cmd_cur.dphase ? gb_din : lat_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    // guest bus drive
    for (genvar g = 0; g < NUM_GUEST; g++) begin : g_cs
        assign gb_cs_n[g] = !(cs_act && (cmd_cur.guest == g));
    end

    always_comb begin
        gb_ale  = strb_act && cmd_cur.wr && !cmd_cur.dphase;
        gb_wr_n = !(strb_act && cmd_cur.wr && cmd_cur.dphase);
        gb_rd_n = !(strb_act && !cmd_cur.wr && cmd_cur.dphase);
        gb_addr = lat_val;
        gb_dout = (cs_act && cmd_cur.wr) ? cmd_cur.val : '0;
    end

    // host read-back
    always_comb begin
        host_rdata = '0;
        if (host_addr == CMD_OFF) begin
            host_rdata[POS_PEND]     = busy;
            host_rdata[BYTE_W-1:0]   = h_q.rd;
        end
    end
endmodule

// File: rtl/gbb_chk.sv
module gbb_chk #(
    parameter int                 HADDR_W = 12,
    parameter logic [HADDR_W-1:0] CMD_OFF = 12'h200
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HADDR_W-1:0] host_addr,
    input logic [31:0]        host_rdata,
    input logic [1:0]         gb_cs_n,
    input logic               gb_ale,
    input logic               gb_rd_n,
    input logic               gb_wr_n
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gb_cs_n)); // R4

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~gb_rd_n, ~gb_wr_n, gb_ale}) <= 1); // R5

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!gb_rd_n || !gb_wr_n || gb_ale) |-> (gb_cs_n != 2'b11)); // R5

    AST_HOLD_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gb_rd_n) |-> (gb_cs_n != 2'b11)); // R5

    AST_HOLD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gb_wr_n) |-> (gb_cs_n != 2'b11)); // R5

    AST_PEND_IS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == CMD_OFF) |-> (host_rdata[25] == (gb_cs_n != 2'b11))); // R3

    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata & ~32'h0200_00FF) == 32'h0); // R12
endmodule

bind guest_bus_bridge gbb_chk #(.HADDR_W(HADDR_W), .CMD_OFF(CMD_OFF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_rdata(host_rdata),
    .gb_cs_n   (gb_cs_n),
    .gb_ale    (gb_ale),
    .gb_rd_n   (gb_rd_n),
    .gb_wr_n   (gb_wr_n)
);

// File: tb/test_guest_bus_bridge.sv
module test_guest_bus_bridge;
    localparam int N = 4;
    localparam logic [11:0] OFF = 12'h200;

    logic        clk = 0, rst_n = 0;
    logic [11:0] host_addr = OFF;
    logic        host_we = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic [1:0]  gb_cs_n;
    logic        gb_ale, gb_rd_n, gb_wr_n;
    logic [7:0]  gb_addr, gb_dout, gb_din = 0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] lat [2];
    logic [7:0] last_rd;

    always #2.5 clk = ~clk;

    guest_bus_bridge #(.STRB_CLKS(N)) i_guest_bus_bridge (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .gb_cs_n(gb_cs_n),
        .gb_ale(gb_ale), .gb_rd_n(gb_rd_n), .gb_wr_n(gb_wr_n),
        .gb_addr(gb_addr), .gb_dout(gb_dout), .gb_din(gb_din)
    );

    function automatic logic [31:0] mk(bit g, bit wr, bit dp, logic [7:0] b);
        logic [31:0] w = 32'h0;
        w[20] = g; w[23] = wr; w[16] = dp; w[7:0] = b;
        return w;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // strobe vector {ale, ~rd_n, ~wr_n} expected during strobe clocks
    function automatic logic [2:0] strb_exp(bit wr, bit dp);
        if (wr && !dp) return 3'b100;
        if (!wr && dp) return 3'b010;
        if (wr && dp)  return 3'b001;
        return 3'b000;
    endfunction

    // called at a negedge; returns at the negedge after the cycle completes
    task automatic run_cmd(bit g, bit wr, bit dp, logic [7:0] b, bit inj, int inj_k);
        logic [7:0] din_f = 8'($urandom);
        logic [7:0] exp_addr;
        logic [1:0] exp_cs = g ? 2'b01 : 2'b10;
        logic [2:0] sv;
        if (wr && !dp) lat[g] = b;   // R6 latch loads at acceptance
        exp_addr = lat[g];
        host_addr = OFF;
        host_wdata = mk(g, wr, dp, b);
        host_we = 1;
        gb_din = ~din_f;
        for (int k = 1; k <= N + 3; k++) begin
            @(negedge clk);
            sv = {gb_ale, ~gb_rd_n, ~gb_wr_n};
            if (k <= N + 2) begin
                chk(host_rdata[25] == 1'b1, "R3 pending set", host_rdata, 32'h0200_0000);
                chk(gb_cs_n == exp_cs, "R4 guest select", gb_cs_n, exp_cs);
                if (k == 1 || k == N + 2)
                    chk(sv == 3'b000, "R5 setup/hold no strobe", sv, 0);
                else
                    chk(sv == strb_exp(wr, dp), "R5 strobe width/kind", sv, strb_exp(wr, dp));
                chk(gb_addr == exp_addr, wr && !dp ? "R6 address byte" : "R7/R8 latched address (R11)",
                    gb_addr, exp_addr);
                if (wr) chk(gb_dout == b, "R7 write data (R11)", gb_dout, b);
            end else begin
                chk(host_rdata[25] == 1'b0, "R3 pending clears", host_rdata, 0);
                chk(gb_cs_n == 2'b11, "R3 cs released", gb_cs_n, 2'b11);
                if (!wr) last_rd = dp ? din_f : lat[g];
                chk(host_rdata[7:0] == last_rd,
                    !wr ? (dp ? "R8 read data" : "R9 address readback") : "R12 read data held",
                    host_rdata[7:0], last_rd);
                chk((host_rdata & ~32'h0200_00FF) == 0, "R12 zero bits", host_rdata, 0);
            end
            if (k == 1) host_we = 0;
            if (inj && k == inj_k) begin
                host_we = 1;
                host_wdata = mk(~g, 1'b1, 1'b0, ~lat[~g]); // R11 injected while pending
            end
            if (inj && k == inj_k + 1) host_we = 0;
            if (k == N + 1) gb_din = din_f;
            if (k == N + 2) gb_din = ~din_f;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        lat[0] = 0; lat[1] = 0; last_rd = 0;
        repeat (3) @(negedge clk);
        // R1 reset state (still in reset)
        chk(host_rdata == 32'h0, "R1 reset rdata", host_rdata, 0);
        chk(gb_cs_n == 2'b11 && gb_rd_n && gb_wr_n && !gb_ale, "R1 reset strobes",
            {gb_cs_n, gb_rd_n, gb_wr_n, gb_ale}, 5'b11110);
        rst_n = 1;
        @(negedge clk);
        // R1 latches clear: address reads
        run_cmd(0, 0, 0, 8'h00, 0, 0);
        chk(host_rdata[7:0] == 8'h00, "R1 latch0 reset", host_rdata, 0);
        run_cmd(1, 0, 0, 8'h00, 0, 0);
        chk(host_rdata[7:0] == 8'h00, "R1 latch1 reset", host_rdata, 0);

        // R2 write at wrong offset ignored
        host_addr = 12'h1FC; host_wdata = mk(0, 1, 0, 8'hEE); host_we = 1;
        @(negedge clk); host_we = 0;
        chk(gb_cs_n == 2'b11, "R2 wrong offset no cycle", gb_cs_n, 2'b11);
        host_addr = OFF;
        @(negedge clk);
        chk(host_rdata[25] == 0, "R2 wrong offset no pending", host_rdata, 0);

        // R10 directed: independent latches
        run_cmd(0, 1, 0, 8'h5A, 0, 0);
        run_cmd(1, 1, 0, 8'hC3, 0, 0);
        run_cmd(0, 0, 0, 8'h00, 0, 0);
        chk(host_rdata[7:0] == 8'h5A, "R10 guest0 latch kept", host_rdata, 8'h5A);
        run_cmd(1, 1, 1, 8'h77, 0, 0);   // R7 data write
        run_cmd(0, 0, 1, 8'h00, 0, 0);   // R8 data read
        run_cmd(1, 1, 1, 8'h11, 0, 0);   // R12 held across write
        // R11 directed: inject at first and at last pending clock
        run_cmd(0, 0, 1, 8'h00, 1, 1);
        run_cmd(1, 1, 1, 8'h3C, 1, N + 2);
        run_cmd(0, 0, 0, 8'h00, 0, 0);
        run_cmd(1, 0, 0, 8'h00, 0, 0);

        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 300; i++) begin
            bit inj = ($urandom % 3) == 0;
            if (($urandom % 16) == 0) begin
                host_addr = 12'($urandom) & 12'hDFF; host_we = 1;
                host_wdata = mk(1'($urandom), 1, 0, 8'($urandom));
                @(negedge clk); host_we = 0; host_addr = OFF;
                chk(gb_cs_n == 2'b11, "R2 random wrong offset", gb_cs_n, 2'b11);
            end
            run_cmd(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                    inj, 1 + ($urandom % (N + 2)));
        end
        run_cmd(0, 0, 0, 8'h00, 0, 0);
        run_cmd(1, 0, 0, 8'h00, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule